// File: doc/BRIEF.md
# Dual-Format SPI Master Serializer

A synchronous serial master that exchanges 8-bit words over SCLK/MOSI/MISO. Words enter through a valid/ready handshake into a single holding slot. Each received word leaves with a one-cycle valid strobe. A format input chooses between two framing styles.

In select framing, an active-low select brackets each byte. The clock polarity and phase are configurable, and an optional hold mode keeps the select low across a run of words so that a serial memory can be driven. In pulse framing, the select stays inactive. An active-high frame strobe lasting one bit period announces every word, and back-to-back words stream without idle clocks.

The format, polarity, phase, hold and divider settings are captured when a transaction starts. They take effect again only after the block has returned to idle.

Top module: `spi_dual_master`

## Requirements
- R1: fmt_i=0 selects select framing: cs_no frames the words and fss_o stays low. fmt_i=1 selects pulse framing: fss_o frames the words and cs_no stays high.
- R2: Each word is 8 bits, shifted MSB first. The word on MOSI and the word taken from MISO are exchanged in the same frame.
- R3: In select framing, SCLK idles at cpol_i. With cpha_i=0, MOSI is valid before the first edge, data is sampled on leading edges and launched on trailing edges. With cpha_i=1, data is launched on leading edges and sampled on trailing edges. All four polarity/phase combinations work.
- R4: In select framing without hold, cs_no returns high after every byte, including between queued bytes, so the SCLK edges show a pause longer than one period.
- R5: With hold_cs_i=1, cs_no stays low across words queued back to back and rises once after the last word.
- R6: In pulse framing, fss_o is high for exactly one SCLK period and rises and falls on rising SCLK edges. One pulse precedes the first word, and each later pulse covers the last bit of the preceding word, giving one pulse per word.
- R7: In pulse framing, queued words produce SCLK rising edges evenly spaced at one period, with no idle clocks between words.
- R8: In pulse framing, SCLK idles low. Data is launched on rising edges and sampled on falling edges, whatever the values of cpol_i and cpha_i.
- R9: One SCLK half-period lasts clk_div_i system cycles, with 0 treated as 1, so the SCLK period is an even number of cycles.
- R10: tx_ready_o is high exactly when the one-word holding slot is empty. A word is accepted on tx_valid_i && tx_ready_o, and tx_ready_o is low in the next cycle.
- R11: rx_valid_o pulses for one cycle, on the cycle after the last SCLK edge of a word, with the received word on rx_data_o.
- R12: Format, polarity, phase, hold and divider are latched when a transaction starts. Changes made during a transfer have no effect until the block is idle. While idle, the SCLK level follows the inputs.
- R13: rst_ni is asynchronous and active low. Under reset, cs_no=1, fss_o=0, sclk_o=0, rx_valid_o=0 and tx_ready_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 1 | Framing: 0 select, 1 frame pulse |
| cpol_i | input | 1 | Idle SCLK level, select framing |
| cpha_i | input | 1 | Sampling phase, select framing |
| hold_cs_i | input | 1 | Keep select low across queued words |
| clk_div_i | input | DIV_W | SCLK half-period in system cycles |
| tx_data_i | input | DATA_W | Word to send |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Holding slot empty |
| rx_data_o | output | DATA_W | Received word |
| rx_valid_o | output | 1 | One-cycle receive strobe |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Active-low select |
| fss_o | output | 1 | Active-high frame pulse |

## Verification
The bench runs a bit-level slave model against every polarity/phase pair, hold and non-hold runs, and single and queued words in pulse framing. It checks the data in both directions together with the select transitions, the frame-pulse width and the spacing of SCLK edges. A design that loaded the next word late would show an SCLK gap or a missing pulse in pulse framing. A design that dropped the select in hold mode would produce extra select rises. A design that shifted on the wrong edge would return rotated bytes.

Further tests change the format, polarity and phase inputs in the middle of a word and expect the word to complete unaffected. They also assert reset in the middle of a frame, check that a zero divider behaves like a divider of one, and check that the ready signal stays low while the holding slot is full.

// File: rtl/spi_dm_pkg.sv
package spi_dm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_SETUP, ST_SHIFT, ST_TAIL, ST_GAP
  } st_e;

  typedef struct packed {
    logic fmt;
    logic cpol;
    logic cpha;
    logic hold;
  } cfg_t;
endpackage

// File: rtl/spi_dm_tick.sv
module spi_dm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, lim;

  // zero divider behaves as one
  assign lim    = (half_i == '0) ? '0 : half_i - 1'b1;
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_dm_shreg.sv
module spi_dm_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         preload_i,
  input  logic [W-1:0] data_i,
  input  logic         launch_i,
  input  logic         sample_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic [W-1:0] rx_o,
  output logic [W-1:0] rx_next_o
);
  logic [W-1:0] tx_q, rx_q;
  logic         mosi_q;

  assign rx_next_o = {rx_q[W-2:0], miso_i};
  assign rx_o      = rx_q;
  assign mosi_o    = mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      mosi_q <= 1'b0;
    end else if (load_i) begin
      if (preload_i) begin
        mosi_q <= data_i[W-1];
        tx_q   <= {data_i[W-2:0], 1'b0};
      end else begin
        tx_q   <= data_i;
      end
    end else if (launch_i) begin
      mosi_q <= tx_q[W-1];
      tx_q   <= {tx_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_q <= '0;
    else if (sample_i) rx_q <= rx_next_o;
  end
endmodule

// File: rtl/spi_dual_master.sv
module spi_dual_master
  import spi_dm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fmt_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              hold_cs_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no,
  output logic              fss_o
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] E_LAST = EW'(EDGES - 1);
  localparam logic [EW-1:0] E_PEN  = EW'(EDGES - 2);

  st_e               st_q;
  cfg_t              cfg_q, cfg_in, cfg_cur;
  logic [DIV_W-1:0]  div_q;
  logic [EW-1:0]     e_q;
  logic [DATA_W-1:0] pend_q, rxd_q, rx_w, rx_nx;
  logic              pend_v, cont_q, sclk_q, cs_q, fss_q, rxv_q;
  logic              tick, idle, in_shift, odd_edge, last_edge, launch_odd;
  logic              launch, sample, start, reload_cs, reload_fr, load, preload;

  assign idle      = (st_q == ST_IDLE);
  assign cfg_in    = '{fmt: fmt_i, cpol: cpol_i, cpha: cpha_i, hold: hold_cs_i};
  assign cfg_cur   = idle ? cfg_in : cfg_q;
  assign in_shift  = (st_q == ST_SHIFT) && tick;
  assign odd_edge  = ~e_q[0];
  assign last_edge = (e_q == E_LAST);
  // pulse framing shares the launch-on-first-edge timing
  assign launch_odd = cfg_q.fmt | cfg_q.cpha;
  assign launch    = in_shift && (odd_edge ? launch_odd : (!launch_odd && !last_edge));
  assign sample    = in_shift && (odd_edge ? !launch_odd : launch_odd);
  assign start     = idle && pend_v;
  assign reload_cs = (st_q == ST_TAIL) && tick && cfg_q.hold && pend_v;
  assign reload_fr = in_shift && last_edge && cont_q;
  assign load      = start || reload_cs || reload_fr;
  assign preload   = !cfg_cur.fmt && !cfg_cur.cpha;

  spi_dm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (!idle),
    .half_i (div_q),
    .tick_o (tick)
  );

  spi_dm_shreg #(.W(DATA_W)) u_shreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .preload_i (preload),
    .data_i    (pend_q),
    .launch_i  (launch),
    .sample_i  (sample),
    .miso_i    (miso_i),
    .mosi_o    (mosi_o),
    .rx_o      (rx_w),
    .rx_next_o (rx_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v <= 1'b0;
      pend_q <= '0;
    end else if (load) begin
      pend_v <= 1'b0;
    end else if (tx_valid_i && !pend_v) begin
      pend_v <= 1'b1;
      pend_q <= tx_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      div_q  <= '0;
      e_q    <= '0;
      cont_q <= 1'b0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      fss_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          sclk_q <= fmt_i ? 1'b0 : cpol_i;
          cs_q   <= 1'b1;
          fss_q  <= 1'b0;
          e_q    <= '0;
          cont_q <= 1'b0;
          if (pend_v) begin
            cfg_q <= cfg_in;
            div_q <= clk_div_i;
            if (fmt_i) begin
              sclk_q <= 1'b0;
              st_q   <= ST_LEAD;
            end else begin
              cs_q <= 1'b0;
              st_q <= ST_SETUP;
            end
          end
        end
        ST_LEAD: if (tick) begin
          // one full clock with the frame pulse ahead of the first word
          sclk_q <= ~sclk_q;
          if (!sclk_q) fss_q <= 1'b1;
          else         st_q  <= ST_SHIFT;
        end
        ST_SETUP: if (tick) st_q <= ST_SHIFT;
        ST_SHIFT: if (tick) begin
          sclk_q <= ~sclk_q;
          e_q    <= e_q + 1'b1;
          if (cfg_q.fmt && odd_edge) begin
            fss_q  <= (e_q == E_PEN) && pend_v;
            cont_q <= (e_q == E_PEN) && pend_v;
          end
          if (last_edge) begin
            e_q    <= '0;
            cont_q <= 1'b0;
            if (!cfg_q.fmt)   st_q <= ST_TAIL;
            else if (!cont_q) st_q <= ST_IDLE;
          end
        end
        ST_TAIL: if (tick) begin
          if (cfg_q.hold && pend_v) begin
            st_q <= ST_SETUP;
          end else begin
            cs_q <= 1'b1;
            st_q <= ST_GAP;
          end
        end
        ST_GAP: if (tick) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxv_q <= 1'b0;
      rxd_q <= '0;
    end else begin
      rxv_q <= in_shift && last_edge;
      if (in_shift && last_edge) rxd_q <= launch_odd ? rx_nx : rx_w;
    end
  end

  assign tx_ready_o = !pend_v;
  assign rx_data_o  = rxd_q;
  assign rx_valid_o = rxv_q;
  assign sclk_o     = sclk_q;
  assign cs_no      = cs_q;
  assign fss_o      = fss_q;
endmodule

// File: rtl/spi_dual_master_chk.sv
module spi_dual_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic rx_valid_o,
  input logic sclk_o,
  input logic cs_no,
  input logic fss_o
);
  AST_FRAMING_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !fss_o); // R1
  AST_FSS_RISE_ON_SCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fss_o) |-> $rose(sclk_o)); // R6
  AST_FSS_FALL_ON_SCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fss_o) |-> $rose(sclk_o)); // R6
  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && tx_ready_o |=> !tx_ready_o); // R10
  AST_RX_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R11
  AST_RX_AFTER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !$stable(sclk_o)); // R11
endmodule

bind spi_dual_master spi_dual_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o),
  .rx_valid_o (rx_valid_o),
  .sclk_o     (sclk_o),
  .cs_no      (cs_no),
  .fss_o      (fss_o)
);

// File: tb/sim_spi_dual_master.sv
`timescale 1ns/1ps
module sim_spi_dual_master;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fmt_i = 0, cpol_i = 0, cpha_i = 0, hold_cs_i = 0;
  logic [7:0] clk_div_i = 8'd1;
  logic [7:0] tx_data_i = '0;
  logic       tx_valid_i = 0;
  logic       tx_ready_o, rx_valid_o, sclk_o, mosi_o, cs_no, fss_o;
  logic [7:0] rx_data_o;
  logic       miso = 1'b0;

  always #2 clk = ~clk;

  spi_dual_master u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fmt_i(fmt_i), .cpol_i(cpol_i), .cpha_i(cpha_i),
    .hold_cs_i(hold_cs_i), .clk_div_i(clk_div_i), .tx_data_i(tx_data_i),
    .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o),
    .rx_valid_o(rx_valid_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso),
    .cs_no(cs_no), .fss_o(fss_o)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slave model, driven by bench-held settings
  bit         s_en = 0, b_fmt = 0, b_cpol = 0, b_cpha = 0, in_word = 0;
  logic [7:0] s_mb [4];
  logic [7:0] s_got [4];
  logic [7:0] m_got [4];
  logic [7:0] s_tx, s_rx;
  int         s_cnt, l_cnt, s_words;

  task automatic s_launch();
    if (l_cnt == 0) s_tx = (s_words < 4) ? s_mb[s_words] : 8'h00;
    miso  = s_tx[7];
    s_tx  = {s_tx[6:0], 1'b0};
    l_cnt = (l_cnt + 1) % 8;
  endtask

  task automatic s_sample();
    s_rx = {s_rx[6:0], mosi_o};
    s_cnt++;
    if (s_cnt == 8) begin
      if (s_words < 4) s_got[s_words] = s_rx;
      s_words++;
      s_cnt = 0;
      in_word = 0;
    end
  endtask

  always @(negedge cs_no) if (s_en && !b_fmt) begin
    l_cnt = 0; s_cnt = 0;
    if (!b_cpha) s_launch();
  end

  always @(sclk_o) if (s_en) begin
    if (!b_fmt) begin
      if (!cs_no) begin
        if ((sclk_o != b_cpol) ^ b_cpha) s_sample();
        else s_launch();
      end
    end else if (sclk_o) begin
      if (in_word) s_launch();
    end else begin
      if (in_word) s_sample();
      if (fss_o) begin in_word = 1; s_cnt = 0; l_cnt = 0; end
    end
  end

  // port monitors, sampled on the falling system clock
  bit mon_en = 0, have_rise, p_sclk, p_cs, p_fss;
  int gap, min_gap, max_gap, cs_rises, cs_low, fss_pulses, fss_bad, fw, rvw, rv_bad, m_words, exp_w;

  task automatic clear_mon(input int d);
    have_rise = 0; gap = 0; min_gap = 1 << 20; max_gap = 0;
    cs_rises = 0; cs_low = 0; fss_pulses = 0; fss_bad = 0; fw = 0;
    rvw = 0; rv_bad = 0; m_words = 0; s_words = 0; s_cnt = 0; l_cnt = 0; in_word = 0;
    exp_w = 2 * d;
    p_sclk = sclk_o; p_cs = cs_no; p_fss = fss_o;
    for (int i = 0; i < 4; i++) begin s_got[i] = 8'h00; m_got[i] = 8'h00; end
  endtask

  always @(negedge clk) if (mon_en) begin
    gap++;
    if (sclk_o && !p_sclk) begin
      if (have_rise) begin
        if (gap < min_gap) min_gap = gap;
        if (gap > max_gap) max_gap = gap;
      end
      have_rise = 1; gap = 0;
    end
    if (cs_no && !p_cs) cs_rises++;
    if (!cs_no) cs_low = 1;
    if (fss_o) fw++;
    else if (p_fss) begin
      fss_pulses++;
      if (fw != exp_w) fss_bad++;
      fw = 0;
    end
    if (rx_valid_o) begin
      rvw++;
      if (rvw > 1) rv_bad++;
      else begin
        if (m_words < 4) m_got[m_words] = rx_data_o;
        m_words++;
      end
    end else rvw = 0;
    p_sclk = sclk_o; p_cs = cs_no; p_fss = fss_o;
  end

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    tx_data_i = b; tx_valid_i = 1;
    while (!tx_ready_o) @(negedge clk);
    @(negedge clk);
    tx_valid_i = 0;
  endtask

  // {fmt,cpol,cpha,hold} div nwords tx0 tx1 miso0 miso1
  localparam int NV = 10;
  localparam logic [43:0] VEC [NV] = '{
    44'h011A5003C00, 44'h622817EC318, 44'h112F00F55AA, 44'h73212349ABC,
    44'h8115A009600, 44'hE22DEADBEEF, 44'h8120180FF00, 44'h21266992442,
    44'h522C00311EE, 44'h0013C00A500
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog run did not finish");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] txb [2];
    logic [7:0] mb [2];
    int n, d;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13", "cs_no in reset", cs_no, 1);
    chk("R13", "fss_o in reset", fss_o, 0);
    chk("R13", "sclk_o in reset", sclk_o, 0);
    chk("R13", "rx_valid_o in reset", rx_valid_o, 0);
    chk("R13", "tx_ready_o in reset", tx_ready_o, 1);
    rst_ni = 1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      {fmt_i, cpol_i, cpha_i, hold_cs_i} = VEC[v][43:40];
      clk_div_i = {4'h0, VEC[v][39:36]};
      n = int'(VEC[v][35:32]);
      txb[0] = VEC[v][31:24]; txb[1] = VEC[v][23:16];
      mb[0]  = VEC[v][15:8];  mb[1]  = VEC[v][7:0];
      d = (clk_div_i == 0) ? 1 : int'(clk_div_i);
      b_fmt = fmt_i; b_cpol = cpol_i; b_cpha = cpha_i;
      s_mb[0] = mb[0]; s_mb[1] = mb[1]; s_mb[2] = 8'h00; s_mb[3] = 8'h00;
      repeat (3) @(negedge clk);
      // R8 R3 idle level before the transfer
      chk(fmt_i ? "R8" : "R3", "idle sclk", sclk_o, fmt_i ? 0 : int'(cpol_i));
      clear_mon(d);
      s_en = 1; mon_en = 1;
      for (int w = 0; w < n; w++) push(txb[w]);
      wait (m_words >= n);
      repeat (4 * d + 6) @(negedge clk);
      mon_en = 0; s_en = 0;
      for (int w = 0; w < n; w++) begin
        chk("R2", $sformatf("v%0d master rx word %0d", v, w), m_got[w], mb[w]);
        chk("R2", $sformatf("v%0d slave rx word %0d", v, w), s_got[w], txb[w]);
      end
      chk("R11", $sformatf("v%0d rx strobe width", v), rv_bad, 0);
      chk("R9", $sformatf("v%0d sclk period", v), min_gap, 2 * d);
      if (!fmt_i) begin
        chk("R1", $sformatf("v%0d no frame pulse", v), fss_pulses, 0);
        if (hold_cs_i) chk("R5", $sformatf("v%0d select rises", v), cs_rises, 1);
        else chk("R4", $sformatf("v%0d select rises", v), cs_rises, n);
        if (n > 1 && !hold_cs_i)
          chk("R4", $sformatf("v%0d pause between bytes", v), int'(max_gap > 2 * d), 1);
        chk("R3", $sformatf("v%0d idle sclk after", v), sclk_o, int'(cpol_i));
      end else begin
        chk("R1", $sformatf("v%0d select unused", v), cs_low, 0);
        chk("R6", $sformatf("v%0d pulse count", v), fss_pulses, n);
        chk("R6", $sformatf("v%0d pulse width", v), fss_bad, 0);
        chk("R7", $sformatf("v%0d no gap", v), max_gap, 2 * d);
        chk("R8", $sformatf("v%0d idle sclk after", v), sclk_o, 0);
      end
    end

    // R10 handshake and full slot
    fmt_i = 0; cpol_i = 0; cpha_i = 0; hold_cs_i = 0; clk_div_i = 8'd3;
    b_fmt = 0; b_cpol = 0; b_cpha = 0;
    s_mb[0] = 8'h4E; s_mb[1] = 8'hB1;
    repeat (3) @(negedge clk);
    clear_mon(3);
    s_en = 1; mon_en = 1;
    @(negedge clk);
    tx_data_i = 8'h27; tx_valid_i = 1;
    @(negedge clk);
    chk("R10", "ready low after accept", tx_ready_o, 0);
    tx_data_i = 8'hD8;
    while (!tx_ready_o) @(negedge clk);
    @(negedge clk);
    tx_valid_i = 0;
    repeat (10) @(negedge clk);
    chk("R10", "ready low while slot full", tx_ready_o, 0);
    wait (m_words >= 2);
    repeat (20) @(negedge clk);
    mon_en = 0; s_en = 0;
    chk("R10", "ready high when empty", tx_ready_o, 1);
    chk("R10", "second word sent", s_got[1], 8'hD8);

    // R12 mid-transfer setting changes are ignored
    fmt_i = 0; cpol_i = 0; cpha_i = 0; clk_div_i = 8'd2;
    b_fmt = 0; b_cpol = 0; b_cpha = 0;
    s_mb[0] = 8'hC5;
    repeat (3) @(negedge clk);
    clear_mon(2);
    s_en = 1; mon_en = 1;
    push(8'h3C);
    repeat (10) @(negedge clk);
    fmt_i = 1; cpol_i = 1; cpha_i = 1;
    wait (m_words >= 1);
    repeat (14) @(negedge clk);
    mon_en = 0; s_en = 0;
    chk("R12", "rx word unchanged by settings", m_got[0], 8'hC5);
    chk("R12", "tx word unchanged by settings", s_got[0], 8'h3C);
    chk("R12", "no frame pulse mid transfer", fss_pulses, 0);
    chk("R12", "select rose once", cs_rises, 1);
    fmt_i = 0;
    repeat (2) @(negedge clk);
    chk("R12", "idle sclk follows new cpol", sclk_o, 1);

    // R13 reset during a pulse-framed transfer
    fmt_i = 1; cpol_i = 0; cpha_i = 0; clk_div_i = 8'd2;
    repeat (3) @(negedge clk);
    push(8'hAA);
    push(8'h55);
    repeat (12) @(negedge clk);
    rst_ni = 0;
    #1;
    chk("R13", "cs_no on mid reset", cs_no, 1);
    chk("R13", "fss_o on mid reset", fss_o, 0);
    chk("R13", "sclk_o on mid reset", sclk_o, 0);
    chk("R13", "tx_ready_o on mid reset", tx_ready_o, 1);
    @(negedge clk);
    rst_ni = 1;
    repeat (20) @(negedge clk);
    chk("R13", "stays idle after reset", fss_o, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule